// File: doc/BRIEF.md
# Two-Entry Transmit Job Queue

This block is the transmit-side job queue of a small Ethernet MAC. Software describes a frame to send as a buffer start address and a byte length. It writes the address first and the length second. The length write is what places the job in the queue. The queue holds at most two jobs: one being fetched from memory and one waiting behind it. When the running job finishes, the waiting job moves up.

For the running job, the block issues word reads through a valid/ready request port. It issues one request per 4-byte beat, with rising addresses, until the committed length is covered. A memory model or bus adapter sits on the other side of that port. Serialisation onto the PHY, collisions and CRC belong to other blocks.

Status is reported on plain pins:
- a room flag, which software polls before committing a job;
- an idle flag;
- a sticky frame-done bit;
- a sticky overflow bit.

The two sticky bits are cleared by writing ones to them. A one-cycle interrupt pulse marks the end of each frame. Transfers run only while the transmit-enable input is high.

Request port rules:
- The request is transferred on a cycle where `rd_req_valid` and `rd_req_ready` are both high.
- While `rd_req_valid` is high and `rd_req_ready` is low, `rd_req_addr` and `rd_req_last` hold their values.
- The one exception is `tx_en` going low. That withdraws the request at once, and fetching resumes from the same beat when `tx_en` returns high.
- `rd_req_ready` may be held low for any number of cycles.

Top module: `tx_pingpong_queue`

## Requirements
- R1: After reset, the outputs are as follows: room flag 1, idle flag 1, frame-done 0, overflow 0, interrupt 0 and no read request.
- R2: A write with select 0 stores the start address without queuing anything. A write with select 1 commits a job, using bits [10:0] of the data as the byte length and the most recently stored address. One stored address may serve several commits.
- R3: At most two jobs are held. The room flag is 1 exactly when no job is waiting behind the running one. It clears on the cycle after a commit that found room. A length write made while the room flag is 0 leaves the queue unchanged and sets the sticky overflow bit.
- R4: A job of length L issues ceil(L/4) read requests. Their addresses are start, start+4, start+8 and so on. `rd_req_last` is high on the final request only.
- R5: While `rd_req_valid` is high and `rd_req_ready` is low (with `tx_en` high), the request address and last flag hold until the request is accepted.
- R6: Consider the clock edge that accepts the final request of a job. Starting from that edge, `tx_irq` is high for exactly one cycle, and the sticky frame-done bit is set. There is one pulse per job, in commit order.
- R7: A waiting job becomes the running job at the clock edge after the running job's completion edge. Its first request is offered in the cycle after that.
- R8: The idle flag is 1 exactly when there is neither a running job nor a waiting job. No request is offered while the queue is idle.
- R9: A write with select 2 clears frame-done where data bit 0 is 1, and clears overflow where data bit 1 is 1. A completion or overflow event in the same cycle as the clear wins, and the bit stays set.
- R10: While `tx_en` is low, no request is offered and no job completes. Queued jobs are kept and continue once `tx_en` is high.
- R11: A job of length 0 issues no reads. It completes, with an interrupt pulse, on the first enabled cycle after it becomes the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; transfers run only while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 address, 1 length/commit, 2 status clear |
| wr_data | input | 32 | Write data |
| st_room | output | 1 | High when another job can be accepted |
| st_idle | output | 1 | High when no job is running or waiting |
| st_done | output | 1 | Sticky frame-done bit |
| st_ovf | output | 1 | Sticky overflow bit (commit refused) |
| tx_irq | output | 1 | One-cycle pulse per finished frame |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by memory side |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_req_last | output | 1 | Marks the final request of a frame |

## Verification
Some rules are checked by assertions on every cycle:
- requests appear only while transmit is enabled and the queue is not idle;
- a stalled request keeps its address;
- interrupt pulses never last two cycles;
- a refused commit leaves the waiting slot untouched;
- a commit that found room closes the room flag;
- completion and overflow always land in the sticky bits.

Other properties need the bench's scenarios:
- the exact address sequence and beat count per length, including zero and the 11-bit maximum;
- frame order across promotion;
- the one-cycle promotion gap;
- the sticky bit winning over a clear in the same cycle;
- jobs surviving a disabled period.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } txq_sel_e;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;

endpackage

// File: rtl/txq_stage.sv
// Address staging register plus the single waiting-job slot.
module txq_stage
  import txq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             take,
  output logic             pend_valid,
  output logic [AW-1:0]    pend_addr,
  output logic [LEN_W-1:0] pend_len,
  output logic             ovf_evt
);

  logic [AW-1:0] staged_addr;
  logic          addr_wr;
  logic          len_wr;
  logic          commit;

  assign addr_wr = wr_en && (wr_sel == SEL_ADDR);
  assign len_wr  = wr_en && (wr_sel == SEL_LEN);
  assign commit  = len_wr && !pend_valid;
  assign ovf_evt = len_wr && pend_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_addr <= '0;
    end else if (addr_wr) begin
      staged_addr <= wr_data[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_len   <= '0;
    end else if (commit) begin
      pend_valid <= 1'b1;
      pend_addr  <= staged_addr;
      pend_len   <= wr_data[LEN_W-1:0];
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  // R3: a refused commit must not disturb the waiting job
  p_full_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && pend_valid && !take) |=> (pend_valid && $stable(pend_addr) && $stable(pend_len)));

  // R7: a promoted job leaves the waiting slot
  p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pend_valid && !len_wr) |=> !pend_valid);

endmodule

// File: rtl/txq_fetch.sv
// Running job: walks the buffer one beat per accepted request.
module txq_fetch #(
  parameter int AW         = 32,
  parameter int LEN_W      = 11,
  parameter int BEAT_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [LEN_W-1:0] load_len,
  output logic             busy,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic             req_last,
  output logic             fin
);

  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int CNT_W      = LEN_W + 1 - BEAT_SHIFT;

  logic [CNT_W-1:0] left;
  logic [LEN_W:0]   len_round;
  logic [CNT_W-1:0] load_beats;
  logic             hs;

  assign len_round  = {1'b0, load_len} + (LEN_W+1)'(BEAT_BYTES - 1);
  assign load_beats = len_round[LEN_W:BEAT_SHIFT];

  assign req_valid = busy && tx_en && (left != '0);
  assign req_last  = (left == CNT_W'(1));
  assign hs        = req_valid && req_ready;
  assign fin       = busy && tx_en && ((left == '0) || (req_last && hs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      req_addr <= '0;
      left     <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      req_addr <= load_addr;
      left     <= load_beats;
    end else if (fin) begin
      busy     <= 1'b0;
      left     <= '0;
    end else if (hs) begin
      req_addr <= req_addr + AW'(BEAT_BYTES);
      left     <= left - CNT_W'(1);
    end
  end

  // R10: nothing is offered while transmit is disabled
  p_req_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> tx_en);

  // R5: a stalled request holds its address
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!req_valid || $stable(req_addr)));

  // R7: a new job only ever replaces an empty running slot
  p_load_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R6: completion frees the running slot
  p_fin_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);

endmodule

// File: rtl/txq_flags.sv
// Sticky status bits and the completion pulse.
module txq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin,
  input  logic       ovf_evt,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  output logic       st_done,
  output logic       st_ovf,
  output logic       irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done <= 1'b0;
      st_ovf  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= fin;
      if (fin)
        st_done <= 1'b1;
      else if (clr_wr && clr_bits[0])
        st_done <= 1'b0;
      if (ovf_evt)
        st_ovf <= 1'b1;
      else if (clr_wr && clr_bits[1])
        st_ovf <= 1'b0;
    end
  end

  // R9: an event in the clear cycle wins
  p_done_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> st_done);

  // R3: refused commit always lands in the sticky bit
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> st_ovf);

endmodule

// File: rtl/tx_pingpong_queue.sv
module tx_pingpong_queue
  import txq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEN_W      = 11,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          st_room,
  output logic          st_idle,
  output logic          st_done,
  output logic          st_ovf,
  output logic          tx_irq,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  output logic          rd_req_last
);

  logic             pend_valid;
  logic [AW-1:0]    pend_addr;
  logic [LEN_W-1:0] pend_len;
  logic             ovf_evt;
  logic             busy;
  logic             fin;
  logic             take;
  logic             clr_wr;

  assign take    = pend_valid && !busy;
  assign clr_wr  = wr_en && (wr_sel == SEL_STAT);
  assign st_room = !pend_valid;
  assign st_idle = !pend_valid && !busy;

  txq_stage #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_len   (pend_len),
    .ovf_evt    (ovf_evt)
  );

  txq_fetch #(.AW(AW), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .load      (take),
    .load_addr (pend_addr),
    .load_len  (pend_len),
    .busy      (busy),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_req_addr),
    .req_last  (rd_req_last),
    .fin       (fin)
  );

  txq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin      (fin),
    .ovf_evt  (ovf_evt),
    .clr_wr   (clr_wr),
    .clr_bits ({wr_data[STAT_OVF_BIT], wr_data[STAT_DONE_BIT]}),
    .st_done  (st_done),
    .st_ovf   (st_ovf),
    .irq      (tx_irq)
  );

  // R8: an idle queue offers no request
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !rd_req_valid);

  // R6: the completion pulse lasts one cycle
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R3: a commit that found room closes the room flag
  p_room_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_LEN && st_room) |=> !st_room);

endmodule

// File: tb/sim_tx_pingpong_queue.sv
`timescale 1ns/1ps
module sim_tx_pingpong_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic        rd_req_ready = 1'b0;
  logic        st_room, st_idle, st_done, st_ovf, tx_irq;
  logic        rd_req_valid, rd_req_last;
  logic [31:0] rd_req_addr;

  always #5 clk = ~clk;

  tx_pingpong_queue u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .st_room(st_room), .st_idle(st_idle), .st_done(st_done),
    .st_ovf(st_ovf), .tx_irq(tx_irq), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_req_last(rd_req_last)
  );

  int checks = 0;
  int errors = 0;
  int irq_count = 0;
  int push_count = 0;
  bit g_en = 1'b0;
  bit g_rdy = 1'b0;
  bit irq_now = 1'b0;
  logic [31:0] last_addr = '0;

  // expected job list (model)
  logic [31:0] m_next[0:15];
  int          m_rem[0:15];
  int          m_head = 0;
  int          m_tail = 0;

  function automatic int beats_of(input int len);
    return (len + 3) / 4;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, observe 1 ns later
  task automatic step(input bit we, input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    tx_en = g_en;
    rd_req_ready = g_rdy;
    wr_en = we;
    wr_sel = sel;
    wr_data = data;
    if (we && sel == 2'd0) last_addr = data;
    if (we && sel == 2'd1 && st_room) begin
      m_next[m_tail % 16] = last_addr;
      m_rem[m_tail % 16] = beats_of(int'(data[10:0]));
      m_tail++;
      push_count++;
    end
    #1;
    irq_now = tx_irq;
    if (tx_irq) begin
      if (m_head == m_tail) chk(1'b0, "R6 irq with no job", 1, 0);
      else begin
        chk(m_rem[m_head % 16] == 0, "R6 irq before all beats", m_rem[m_head % 16], 0);
        m_head++;
        irq_count++;
      end
    end
    if (rd_req_valid && rd_req_ready) begin
      if (m_head == m_tail || m_rem[m_head % 16] == 0)
        chk(1'b0, "R4 unexpected read", rd_req_addr, 0);
      else begin
        chk(rd_req_addr == m_next[m_head % 16], "R4 read address", rd_req_addr, m_next[m_head % 16]);
        chk(rd_req_last == (m_rem[m_head % 16] == 1), "R4 last flag", rd_req_last, m_rem[m_head % 16] == 1);
        m_next[m_head % 16] = m_next[m_head % 16] + 32'd4;
        m_rem[m_head % 16]--;
      end
    end
  endtask

  task automatic idle_step();
    step(1'b0, 2'd3, 32'd0);
  endtask

  task automatic drain(input string req);
    g_en = 1'b1;
    g_rdy = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      idle_step();
      if (st_idle && m_head == m_tail) break;
    end
    chk(st_idle && m_head == m_tail, req, m_tail - m_head, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    repeat (3) idle_step();
    rst_n = 1'b1;
    idle_step();
    // R1 reset state
    chk(st_room == 1, "R1 room", st_room, 1);
    chk(st_idle == 1, "R1 idle", st_idle, 1);
    chk(st_done == 0, "R1 done", st_done, 0);
    chk(st_ovf == 0, "R1 ovf", st_ovf, 0);
    chk(tx_irq == 0 && rd_req_valid == 0, "R1 irq/req", {tx_irq, rd_req_valid}, 0);

    // R2/R4/R6/R8: single 10-byte job -> 3 reads
    g_en = 1'b1; g_rdy = 1'b1;
    step(1'b1, 2'd0, 32'h0000_1000);
    chk(st_idle == 1, "R2 address write queues nothing", st_idle, 1);
    step(1'b1, 2'd1, 32'd10);
    idle_step();
    chk(st_idle == 0, "R8 busy not idle", st_idle, 0);
    base = irq_count;
    drain("R4 single job drained");
    chk(irq_count == base + 1, "R6 one pulse", irq_count, base + 1);
    chk(st_done == 1, "R6 done sticky", st_done, 1);
    chk(st_room == 1, "R3 room after finish", st_room, 1);

    // R9 clear done
    step(1'b1, 2'd2, 32'd1);
    idle_step();
    chk(st_done == 0, "R9 done cleared", st_done, 0);

    // R3/R10/R7: fill queue while disabled
    g_en = 1'b0;
    step(1'b1, 2'd0, 32'h0000_4000);
    step(1'b1, 2'd1, 32'd20);
    step(1'b1, 2'd0, 32'h0000_8000);
    step(1'b1, 2'd1, 32'd8);
    idle_step();
    chk(st_room == 0, "R3 room clear when two held", st_room, 0);
    chk(st_idle == 0, "R8 not idle", st_idle, 0);
    step(1'b1, 2'd0, 32'h0000_C000);
    step(1'b1, 2'd1, 32'd4);
    idle_step();
    chk(st_ovf == 1, "R3 overflow sticky", st_ovf, 1);
    for (int i = 0; i < 10; i++) begin
      idle_step();
      chk(rd_req_valid == 0 && tx_irq == 0, "R10 quiet while disabled", rd_req_valid, 0);
    end
    g_en = 1'b1; g_rdy = 1'b1;
    base = irq_count;
    for (int i = 0; i < 100; i++) begin
      idle_step();
      if (irq_now) break;
    end
    chk(irq_now == 1, "R10 resumes", irq_now, 1);
    chk(rd_req_valid == 0, "R7 gap before promoted job", rd_req_valid, 0);
    idle_step();
    chk(rd_req_valid == 1 && rd_req_addr == 32'h0000_8000, "R7 promoted first read", rd_req_addr, 32'h0000_8000);
    drain("R7 both jobs drained");
    chk(irq_count == base + 2, "R6 two pulses in order", irq_count, base + 2);

    // R5 stall holds request
    step(1'b1, 2'd2, 32'd1);
    g_rdy = 1'b0;
    step(1'b1, 2'd0, 32'h0000_2000);
    step(1'b1, 2'd1, 32'd12);
    idle_step();
    for (int i = 0; i < 5; i++) begin
      idle_step();
      chk(rd_req_valid == 1 && rd_req_addr == 32'h0000_2000, "R5 stalled request held", rd_req_addr, 32'h0000_2000);
    end
    drain("R5 drained");

    // R11 zero length, R9 set wins over clear
    step(1'b1, 2'd2, 32'd1);
    base = irq_count;
    step(1'b1, 2'd0, 32'h0000_3000);
    step(1'b1, 2'd1, 32'd0);
    idle_step();
    step(1'b1, 2'd2, 32'd1);
    idle_step();
    chk(st_done == 1, "R9 completion wins over clear", st_done, 1);
    chk(irq_count == base + 1, "R11 zero length completes", irq_count, base + 1);
    chk(st_ovf == 1, "R9 ovf untouched by done clear", st_ovf, 1);
    step(1'b1, 2'd2, 32'd2);
    idle_step();
    chk(st_ovf == 0 && st_done == 1, "R9 selective clear", {st_ovf, st_done}, 1);

    // random traffic
    base = irq_count;
    for (int i = 0; i < 6000; i++) begin
      int r;
      g_rdy = ($urandom % 4) != 0;
      g_en = ($urandom % 16) != 0;
      r = $urandom % 8;
      if (r == 0) step(1'b1, 2'd0, $urandom & 32'hFFFF_FFFC);
      else if (r == 1) begin
        int len;
        if ($urandom % 8 == 0) len = 0;
        else if ($urandom % 60 == 0) len = 2047;
        else len = $urandom % 48;
        step(1'b1, 2'd1, 32'(len));
      end else idle_step();
    end
    drain("R4 random drained");
    chk(irq_count == push_count, "R6 pulse per committed job", irq_count, push_count);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule